// File: doc/BRIEF.md
# Highway and Farm Road Junction Signal Controller

This block is a clocked state controller for a junction where a busy highway meets a lightly used farm road. It drives one three-colour light for each road and reads one vehicle sensor on the farm road. The sensor is assumed to be already synchronous and clean. The highway keeps right of way by default. It yields only when a farm vehicle is waiting and the highway has held green for a full long interval. The farm road then gets green until its vehicle leaves or a long interval runs out, whichever comes first. The controller then steps back through farm yellow to the default state.

An internal down-counter sets how long each state lasts. The controller loads it each time it enters a state, with either the short or the long tick count, and it reports expiry when the count reaches zero. Both counts are parameters in clock ticks, so simulation can use small values. A third parameter picks the state register encoding: plain binary, one-hot or Gray. The encoding must not change anything seen at the ports.

Top module: `junction_signal_ctrl`

## Requirements
- R1: Both light outputs use a 2-bit code: 00 red, 01 yellow, 10 green. While synchronous active-high reset is sampled, and in the cycle after it, the highway shows green and the farm road shows red.
- R2: Highway green is held for at least LONG_TICKS cycles after it is entered, counting the entry cycle, even if the farm sensor is asserted for the whole time.
- R3: The highway goes from green to yellow only in the cycle after one in which the sensor was asserted and the long interval had expired. Otherwise it stays green.
- R4: Highway yellow lasts exactly SHORT_TICKS cycles. Then the highway shows red and the farm road shows green in the same cycle.
- R5: Farm green goes to farm yellow in the cycle after the sensor is sampled low, or after LONG_TICKS cycles of farm green with the sensor held high, whichever comes first.
- R6: Farm yellow lasts exactly SHORT_TICKS cycles. Then the farm road shows red and the highway shows green, with the long interval restarted.
- R7: The two roads never show green in the same cycle.
- R8: For every input sequence, the light outputs are identical for ENCODING 0 (binary), 1 (one-hot) and 2 (Gray).
- R9: Once the sensor is asserted while the highway long interval has expired, farm green appears within SHORT_TICKS + 2 cycles.
- R10: Reset is synchronous. Asserting it mid-sequence changes nothing before the next clock edge, and after that edge the outputs are highway green and farm red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| farm_car | input | 1 | Farm road vehicle sensor, high while a vehicle waits |
| hwy_light | output | 2 | Highway light code (00 red, 01 yellow, 10 green) |
| farm_light | output | 2 | Farm road light code (00 red, 01 yellow, 10 green) |

## Verification
A wrong state or a wrong timer value inside this block reaches the ports almost at once. The lights are registered from the next-state value, so a bad transition shows as a wrong colour in the very next cycle. A bad timer load or a bad decrement shows as a yellow or green phase that ends one or more cycles early or late, and this is visible as soon as that phase closes. The bench follows every cycle against an interval model and against the other two encodings, so any such difference is reported within the cycle in which it appears.

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl #(
  parameter int SHORT_TICKS = 10,
  parameter int LONG_TICKS  = 50,
  parameter int ENCODING    = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       farm_car,
  output logic [1:0] hwy_light,
  output logic [1:0] farm_light
);
  localparam int SW = (ENCODING == 1) ? 4 : 2;
  localparam int CW = $clog2(LONG_TICKS + 1);

  function automatic logic [SW-1:0] enc(input int i);
    case (ENCODING)
      1:       enc = SW'(1 << i);
      2:       enc = SW'(i ^ (i >> 1));
      default: enc = SW'(i);
    endcase
  endfunction

  localparam logic [SW-1:0] S_HG = enc(0);
  localparam logic [SW-1:0] S_HY = enc(1);
  localparam logic [SW-1:0] S_FG = enc(2);
  localparam logic [SW-1:0] S_FY = enc(3);

  localparam logic [1:0] RED = 2'b00;
  localparam logic [1:0] YEL = 2'b01;
  localparam logic [1:0] GRN = 2'b10;

  localparam logic [CW-1:0] LOAD_S = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LOAD_L = CW'(LONG_TICKS - 1);

  logic [SW-1:0] state, nxt;
  logic [CW-1:0] cnt;
  logic          expired;

  assign expired = (cnt == '0);

  function automatic logic [1:0] hwy_of(input logic [SW-1:0] s);
    case (s)
      S_HG:    hwy_of = GRN;
      S_HY:    hwy_of = YEL;
      default: hwy_of = RED;
    endcase
  endfunction

  function automatic logic [1:0] farm_of(input logic [SW-1:0] s);
    case (s)
      S_FG:    farm_of = GRN;
      S_FY:    farm_of = YEL;
      default: farm_of = RED;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      S_HG:    if (farm_car && expired) nxt = S_HY;
      S_HY:    if (expired) nxt = S_FG;
      S_FG:    if (!farm_car || expired) nxt = S_FY;
      S_FY:    if (expired) nxt = S_HG;
      default: nxt = S_HG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_HG;
      cnt        <= LOAD_L;
      hwy_light  <= GRN;
      farm_light <= RED;
    end else begin
      state      <= nxt;
      hwy_light  <= hwy_of(nxt);
      farm_light <= farm_of(nxt);
      if (nxt != state)
        cnt <= (nxt == S_HY || nxt == S_FY) ? LOAD_S : LOAD_L;
      else if (!expired)
        cnt <= cnt - 1'b1;
    end
  end

  assert_no_dual_green_R7: assert property (@(posedge clk) disable iff (rst)
    !(hwy_light == GRN && farm_light == GRN));

  assert_yellow_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
    (hwy_light == YEL && $past(hwy_light) == GRN) |-> ($past(farm_car) && $past(expired)));

  assert_farm_green_after_yellow_R4: assert property (@(posedge clk) disable iff (rst)
    (farm_light == GRN && $past(farm_light) != GRN) |-> ($past(hwy_light) == YEL && hwy_light == RED));

  assert_farm_exit_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (farm_light == YEL && $past(farm_light) == GRN) |-> (!$past(farm_car) || $past(expired)));

  assert_long_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (hwy_light == GRN && $past(hwy_light) != GRN) |-> (cnt == LOAD_L));

  generate
    if (ENCODING == 1) begin : g_onehot_chk
      assert_onehot_state_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);
    end
  endgenerate
endmodule

// File: tb/tb_junction_signal_ctrl.sv
module tb_junction_signal_ctrl;
  localparam int S = 3;
  localparam int L = 6;
  localparam logic [1:0] RED = 2'b00, YEL = 2'b01, GRN = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic farm_car = 1'b0;
  logic [1:0] hw0, fm0, hw1, fm1, hw2, fm2;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  junction_signal_ctrl #(.SHORT_TICKS(S), .LONG_TICKS(L), .ENCODING(0)) dut (
    .clk(clk), .rst(rst), .farm_car(farm_car), .hwy_light(hw0), .farm_light(fm0));
  junction_signal_ctrl #(.SHORT_TICKS(S), .LONG_TICKS(L), .ENCODING(1)) dut_oh (
    .clk(clk), .rst(rst), .farm_car(farm_car), .hwy_light(hw1), .farm_light(fm1));
  junction_signal_ctrl #(.SHORT_TICKS(S), .LONG_TICKS(L), .ENCODING(2)) dut_gr (
    .clk(clk), .rst(rst), .farm_car(farm_car), .hwy_light(hw2), .farm_light(fm2));

  // Interval model: phase 0 hwy green, 1 hwy yellow, 2 farm green, 3 farm yellow
  int m_ph = 0;
  int m_age = 0;

  function automatic int lim_of(input int ph);
    return (ph == 1 || ph == 3) ? S : L;
  endfunction
  function automatic logic [1:0] exp_hwy(input int ph);
    return ph == 0 ? GRN : (ph == 1 ? YEL : RED);
  endfunction
  function automatic logic [1:0] exp_farm(input int ph);
    return ph == 2 ? GRN : (ph == 3 ? YEL : RED);
  endfunction

  always @(posedge clk) begin
    int nph;
    bit full;
    cycles <= cycles + 1;
    if (rst) begin
      m_ph  <= 0;
      m_age <= 0;
    end else begin
      full = (m_age >= lim_of(m_ph) - 1);
      nph = m_ph;
      case (m_ph)
        0: if (farm_car && full) nph = 1;
        1: if (full) nph = 2;
        2: if (!farm_car || full) nph = 3;
        default: if (full) nph = 0;
      endcase
      m_ph  <= nph;
      m_age <= (nph != m_ph) ? 0 : m_age + 1;
    end
  end

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Every-cycle comparison against the model and across encodings
  always @(negedge clk) begin
    if (cycles > 0 && !done) begin
      string tag;
      case (m_ph)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R5";
        default: tag = "R6";
      endcase
      chk(tag, hw0, exp_hwy(m_ph));
      chk(tag, fm0, exp_farm(m_ph));
      chk("R8", {hw1, fm1}, {hw0, fm0});
      chk("R8", {hw2, fm2}, {hw0, fm0});
      checks++;
      if (hw0 == GRN && fm0 == GRN) begin
        fails++;
        $display("FAIL R7: actual both green expected at most one green");
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd5179));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", hw0, GRN);
    chk("R1", fm0, RED);
    rst = 1'b0;

    // R2: sensor high from the start, highway holds green for the minimum dwell
    farm_car = 1'b1;
    for (int i = 0; i < L - 1; i++) begin
      step();
      chk("R2", hw0, GRN);
    end
    step();
    chk("R3", hw0, YEL);
    chk("R3", fm0, RED);
    for (int i = 0; i < S - 1; i++) begin
      step();
      chk("R4", hw0, YEL);
    end
    step();
    chk("R4", hw0, RED);
    chk("R4", fm0, GRN);

    // R5: farm green ends by the long interval with the sensor held high
    for (int i = 0; i < L - 1; i++) begin
      step();
      chk("R5", fm0, GRN);
    end
    step();
    chk("R5", fm0, YEL);
    for (int i = 0; i < S - 1; i++) begin
      step();
      chk("R6", fm0, YEL);
    end
    step();
    chk("R6", fm0, RED);
    chk("R6", hw0, GRN);
    for (int i = 0; i < L - 1; i++) begin
      step();
      chk("R6", hw0, GRN);
    end
    step();
    chk("R3", hw0, YEL);
    repeat (S) step();
    chk("R4", fm0, GRN);

    // R5: early end when the vehicle clears the sensor
    step();
    chk("R5", fm0, GRN);
    farm_car = 1'b0;
    step();
    chk("R5", fm0, YEL);
    repeat (S) step();
    chk("R6", hw0, GRN);

    // R3: no request, highway stays green past expiry
    repeat (L + 2) begin
      step();
      chk("R3", hw0, GRN);
    end

    // R9: liveness bound once requested after expiry
    farm_car = 1'b1;
    n = 0;
    while (fm0 != GRN && n < 4 * S + 8) begin
      step();
      n++;
    end
    checks++;
    if (n > S + 2) begin
      fails++;
      $display("FAIL R9: actual %0d cycles expected at most %0d", n, S + 2);
    end

    // R10: synchronous reset during farm green
    rst = 1'b1;
    #1;
    chk("R10", fm0, GRN);
    chk("R10", hw0, RED);
    step();
    chk("R10", hw0, GRN);
    chk("R10", fm0, RED);
    rst = 1'b0;

    // Random sensor traffic, compared every cycle by the model process
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) farm_car = ~farm_car;
      if ($urandom_range(0, 599) == 0) rst = 1'b1;
      else rst = 1'b0;
      step();
    end
    rst = 1'b0;
    step();
    finish_run();
  end
endmodule